// File: doc/BRIEF.md
# Shared-Bus Tenure Controller

This block sits on the master side of a bus that several masters share. It follows which master holds the bus by watching the shared transfer-start, bus-busy and tenure-termination lines. From that it decides when the local master may take the bus, start a transfer and hand the bus back. A master that receives a grant does not take the bus while another master still holds a tenure that it opened with a transfer start. It waits until that tenure visibly ends.

The local bus-busy line is either driven asserted or left floating. Whenever the local master gives the bus up, a one-clock end-of-tenure state drives the line negated before it floats. The functional reset request `hold_rst` never cuts an active tenure short. An owning master is sent through that end-of-tenure state first.

Top module: `bus_tenure_ctl`

## Requirements
- R1: While `rst_n` is low, `tenure_state` is 0 and `bb_oe`, `bb_out`, `ts_out` and `own` are 0. The state codes are: 0 idle-reset, 1 other-master implicit, 2 other-master explicit, 3 snooping, 4 local implicit, 5 local explicit, 6 end tenure.
- R2: With `hold_rst` high, every state other than 5 and 6 goes to 0 on the next clock. State 5 goes to 6, and state 6 goes to 0.
- R3: In state 0 with `hold_rst` low, the next state is 2 if a foreign start is pending. Otherwise it is 4 when `grant` is high and 1 when `grant` is low.
- R4: A foreign start becomes pending when `ts_in` is seen high while `own` is low. It is cleared by a tenure change: `tt_in` high, or `bb_in` low one clock after it was high. When a clock sees both a new start and a tenure change, the start wins. While a start is pending, state 1 never moves to 4, even if `grant` is high.
- R5: In state 1, `ts_in` high leads to 2. Otherwise `grant` high with no pending start leads to 4. Otherwise the state stays at 1.
- R6: In state 2, `snoop_hit` high leads to 3. Otherwise, on a tenure change the state moves to 4 if `grant` is high and to 1 if it is low. With neither, it stays at 2.
- R7: State 3 stays while `snoop_hit` is high and returns to 2 when it drops.
- R8: In state 4, losing `grant` leads to 2 if `ts_in` is high and to 1 if it is low. With `grant` held high, `xfer_req` high leads to 5.
- R9: State 5 goes to 6 when `xfer_done` is high and either `grant` or `xfer_req` is low. State 6 lasts exactly one clock, then goes to 4 if `grant` is high and to 1 if it is low.
- R10: In state 5, `bb_oe`=1 and `bb_out`=1. In state 6, `bb_oe`=1 and `bb_out`=0. In all other states both are 0.
- R11: `ts_out` is high only in the first clock of state 5, as a single-cycle pulse. `own` is high exactly in states 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_rst | input | 1 | Functional reset request, sampled on the clock |
| grant | input | 1 | Bus grant from the arbiter |
| ts_in | input | 1 | Transfer start seen on the bus from another master |
| bb_in | input | 1 | Bus-busy level seen on the bus |
| tt_in | input | 1 | Tenure termination seen on the bus |
| xfer_req | input | 1 | Local transfer pending |
| xfer_done | input | 1 | Local transfer finishing this clock |
| snoop_hit | input | 1 | Foreign access marked snoopable |
| bb_out | output | 1 | Local bus-busy drive value |
| bb_oe | output | 1 | Local bus-busy output enable |
| ts_out | output | 1 | Local transfer-start pulse |
| own | output | 1 | Local master owns the bus |
| tenure_state | output | 3 | Current state code |

## Verification
Each input combination is sampled at a rising edge, and the new state code appears right after that same edge. `bb_out`, `bb_oe` and `own` are decoded from the state register, so they change in the same cycle as the state. `ts_out` comes from a register loaded on the move from 4 to 5, so it is due in the first cycle of state 5. The bench changes inputs 1 ns after a rising edge and compares every output 1 ns after the next rising edge. It places the bench's model of each state at every one of the 7 states and applies all 256 input combinations there. Directed sequences cover the bus-busy falling edge and a foreign start that is pending across reset.

// File: rtl/bten_pkg.sv
package bten_pkg;
  typedef enum logic [2:0] {
    ST_RST    = 3'd0,
    ST_AM_IMP = 3'd1,
    ST_AM_EXP = 3'd2,
    ST_SNOOP  = 3'd3,
    ST_IMP    = 3'd4,
    ST_EXP    = 3'd5,
    ST_END    = 3'd6
  } tenure_e;
  localparam int unsigned ST_W = 3;
endpackage

// File: rtl/bten_watch.sv
module bten_watch #(
  parameter bit USE_BB_EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ts_in,
  input  logic bb_in,
  input  logic tt_in,
  input  logic own,
  output logic fpend,
  output logic tchg
);
  logic bb_q;
  logic fpend_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bb_q <= 1'b0;
    else        bb_q <= bb_in;
  end

  generate
    if (USE_BB_EDGE) begin : g_edge
      assign tchg = tt_in | (bb_q & ~bb_in);
    end else begin : g_tt_only
      logic unused_bbq;
      assign unused_bbq = bb_q;
      assign tchg = tt_in;
    end
  endgenerate

  // A new foreign start outranks a tenure change seen in the same clock.
  always_comb begin
    fpend_nxt = fpend;
    if (ts_in && !own) fpend_nxt = 1'b1;
    else if (tchg)     fpend_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fpend <= 1'b0;
    else        fpend <= fpend_nxt;
  end

  AST_FPEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_in && !own) |=> fpend); // R4
endmodule

// File: rtl/bten_bbdrv.sv
module bten_bbdrv
  import bten_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  tenure_e cur,
  output logic    bb_out,
  output logic    bb_oe,
  output logic    own
);
  always_comb begin
    bb_out = 1'b0;
    bb_oe  = 1'b0;
    own    = 1'b0;
    unique case (cur)
      ST_EXP:  begin bb_out = 1'b1; bb_oe = 1'b1; own = 1'b1; end
      ST_END:  begin bb_out = 1'b0; bb_oe = 1'b1; own = 1'b1; end
      ST_IMP:  own = 1'b1;
      default: ;
    endcase
  end

  AST_BB_NEG_THEN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bb_oe && !bb_out) |=> !bb_oe); // R10
  AST_BB_NO_DIRECT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bb_oe && bb_out) |=> bb_oe); // R10
endmodule

// File: rtl/bten_fsm.sv
module bten_fsm
  import bten_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hold_rst,
  input  logic    grant,
  input  logic    ts_in,
  input  logic    xfer_req,
  input  logic    xfer_done,
  input  logic    snoop_hit,
  input  logic    fpend,
  input  logic    tchg,
  output tenure_e cur,
  output logic    ts_out
);
  tenure_e nxt;
  logic    ts_nxt;

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_RST: begin
        if (!hold_rst) begin
          if (fpend)      nxt = ST_AM_EXP;
          else if (grant) nxt = ST_IMP;
          else            nxt = ST_AM_IMP;
        end
      end
      ST_AM_IMP: begin
        if (hold_rst)               nxt = ST_RST;
        else if (ts_in)             nxt = ST_AM_EXP;
        else if (grant && !fpend)   nxt = ST_IMP;
      end
      ST_AM_EXP: begin
        if (hold_rst)       nxt = ST_RST;
        else if (snoop_hit) nxt = ST_SNOOP;
        else if (tchg)      nxt = grant ? ST_IMP : ST_AM_IMP;
      end
      ST_SNOOP: begin
        if (hold_rst)        nxt = ST_RST;
        else if (!snoop_hit) nxt = ST_AM_EXP;
      end
      ST_IMP: begin
        if (hold_rst)      nxt = ST_RST;
        else if (!grant)   nxt = ts_in ? ST_AM_EXP : ST_AM_IMP;
        else if (xfer_req) nxt = ST_EXP;
      end
      ST_EXP: begin
        if (hold_rst)                                nxt = ST_END;
        else if (xfer_done && (!grant || !xfer_req)) nxt = ST_END;
      end
      ST_END: begin
        if (hold_rst)   nxt = ST_RST;
        else if (grant) nxt = ST_IMP;
        else            nxt = ST_AM_IMP;
      end
      default: nxt = ST_RST;
    endcase
  end

  assign ts_nxt = (cur == ST_IMP) && (nxt == ST_EXP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= ST_RST;
      ts_out <= 1'b0;
    end else begin
      cur    <= nxt;
      ts_out <= ts_nxt;
    end
  end

  AST_EXP_VIA_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == ST_EXP && hold_rst) |=> (cur == ST_END)); // R2
  AST_HOLD_TO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rst && cur != ST_EXP && cur != ST_END) |=> (cur == ST_RST)); // R2
  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == ST_END) |=> (cur != ST_END)); // R9
  AST_NO_GRAB_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == ST_AM_IMP && fpend) |=> (cur != ST_IMP)); // R4
  AST_TS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ts_out |=> !ts_out); // R11
  AST_TS_IN_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    ts_out |-> (cur == ST_EXP)); // R11
endmodule

// File: rtl/bus_tenure_ctl.sv
module bus_tenure_ctl
  import bten_pkg::*;
#(
  parameter bit USE_BB_EDGE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_rst,
  input  logic            grant,
  input  logic            ts_in,
  input  logic            bb_in,
  input  logic            tt_in,
  input  logic            xfer_req,
  input  logic            xfer_done,
  input  logic            snoop_hit,
  output logic            bb_out,
  output logic            bb_oe,
  output logic            ts_out,
  output logic            own,
  output logic [ST_W-1:0] tenure_state
);
  tenure_e cur;
  logic    fpend;
  logic    tchg;

  bten_watch #(.USE_BB_EDGE(USE_BB_EDGE)) u_watch (
    .clk(clk), .rst_n(rst_n), .ts_in(ts_in), .bb_in(bb_in), .tt_in(tt_in),
    .own(own), .fpend(fpend), .tchg(tchg)
  );

  bten_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst), .grant(grant),
    .ts_in(ts_in), .xfer_req(xfer_req), .xfer_done(xfer_done),
    .snoop_hit(snoop_hit), .fpend(fpend), .tchg(tchg),
    .cur(cur), .ts_out(ts_out)
  );

  bten_bbdrv u_bb (
    .clk(clk), .rst_n(rst_n), .cur(cur),
    .bb_out(bb_out), .bb_oe(bb_oe), .own(own)
  );

  assign tenure_state = cur;

  AST_OWN_MATCHES_OE: assert property (@(posedge clk) disable iff (!rst_n)
    bb_oe |-> own); // R11
endmodule

// File: tb/sim_bus_tenure_ctl.sv
`timescale 1ns/100ps
module sim_bus_tenure_ctl;
  logic clk = 1'b0;
  logic rst_n;
  logic hold_rst, grant, ts_in, bb_in, tt_in, xfer_req, xfer_done, snoop_hit;
  logic bb_out, bb_oe, ts_out, own;
  logic [2:0] tenure_state;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int m_st, m_fp, m_bbq, m_ts;

  always #2.5 clk = ~clk;

  bus_tenure_ctl u0 (
    .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst), .grant(grant),
    .ts_in(ts_in), .bb_in(bb_in), .tt_in(tt_in), .xfer_req(xfer_req),
    .xfer_done(xfer_done), .snoop_hit(snoop_hit), .bb_out(bb_out),
    .bb_oe(bb_oe), .ts_out(ts_out), .own(own), .tenure_state(tenure_state)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Next state from the requirements; c bits: 0 hold,1 grant,2 ts,3 bb,4 tt,5 req,6 done,7 snoop
  function automatic int model_next(int st, logic [7:0] c, int fp, int bbq);
    int n;
    bit tchg;
    tchg = c[4] || (bbq != 0 && !c[3]);
    n = st;
    case (st)
      0: if (!c[0]) n = (fp != 0) ? 2 : (c[1] ? 4 : 1);
      1: if (c[0]) n = 0; else if (c[2]) n = 2; else if (c[1] && fp == 0) n = 4;
      2: if (c[0]) n = 0; else if (c[7]) n = 3; else if (tchg) n = c[1] ? 4 : 1;
      3: if (c[0]) n = 0; else if (!c[7]) n = 2;
      4: if (c[0]) n = 0; else if (!c[1]) n = c[2] ? 2 : 1; else if (c[5]) n = 5;
      5: if (c[0] || (c[6] && (!c[1] || !c[5]))) n = 6;
      6: if (c[0]) n = 0; else n = c[1] ? 4 : 1;
      default: n = 0;
    endcase
    return n;
  endfunction

  function automatic string state_tag(int st, bit hold);
    if (hold) return "R2";
    case (st)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [7:0] c, input string tag_ovr);
    int n;
    bit own_m, tchg;
    string tg;
    own_m = (m_st >= 4 && m_st <= 6);
    tchg = c[4] || (m_bbq != 0 && !c[3]);
    n = model_next(m_st, c, m_fp, m_bbq);
    tg = (tag_ovr != "") ? tag_ovr : state_tag(m_st, c[0]);
    if (c[2] && !own_m) m_fp = 1; else if (tchg) m_fp = 0;
    m_ts = (m_st == 4 && n == 5) ? 1 : 0;
    m_bbq = c[3];
    m_st = n;
    {snoop_hit, xfer_done, xfer_req, tt_in, bb_in, ts_in, grant, hold_rst} = c;
    @(posedge clk);
    #1;
    chk(tg, tenure_state, m_st);
    chk("R10 bb_oe", bb_oe, (m_st == 5 || m_st == 6) ? 1 : 0);
    chk("R10 bb_out", bb_out, (m_st == 5) ? 1 : 0);
    chk("R11 own", own, (m_st >= 4 && m_st <= 6) ? 1 : 0);
    chk("R11 ts_out", ts_out, m_ts);
  endtask

  // Bring model and design to state t with no foreign start pending.
  task automatic goto(input int t);
    apply(8'b0001_0001, "");
    apply(8'b0001_0001, "");
    case (t)
      1: apply(8'h00, "");
      2: begin apply(8'h00, ""); apply(8'h04, ""); end
      3: begin apply(8'h00, ""); apply(8'h04, ""); apply(8'h80, ""); end
      4: apply(8'h02, "");
      5: begin apply(8'h02, ""); apply(8'h22, ""); end
      6: begin apply(8'h02, ""); apply(8'h22, ""); apply(8'h42, ""); end
      default: ;
    endcase
  endtask

  initial begin
    rst_n = 1'b0;
    {snoop_hit, xfer_done, xfer_req, tt_in, bb_in, ts_in, grant, hold_rst} = 8'h0;
    m_st = 0; m_fp = 0; m_bbq = 0; m_ts = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1 state", tenure_state, 0);
    chk("R1 bb_oe", bb_oe, 0);
    chk("R1 outs", {bb_out, ts_out, own}, 0);
    rst_n = 1'b1;

    // Sweep: every state, every input combination
    for (int t = 0; t < 7; t++) begin
      for (int c = 0; c < 256; c++) begin
        goto(t);
        apply(c[7:0], "");
      end
    end

    // R4: start pending across reset blocks grant; bus-busy fall releases it
    goto(0);
    apply(8'h05, "R4");          // hold + ts: pending set, stay 0
    apply(8'h02, "R3");          // release granted: pending -> 2
    apply(8'h0A, "R4");          // bb high, no change yet
    apply(8'h02, "R4");          // bb falls with grant -> 4
    // R4: pending blocks grant in state 1
    goto(1);
    apply(8'h04, "R5");          // ts -> 2, pending
    apply(8'h10, "R6");          // tt, no grant -> 1, pending cleared
    apply(8'h04, "R5");          // ts again -> 2
    apply(8'h00, "R6");
    // R2: hold from explicit goes through end tenure
    goto(5);
    apply(8'h23, "R2");
    apply(8'h23, "R2");
    apply(8'h22, "R3");

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule